// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Compression

This block keeps a short history of taken program-flow changes. Each time the core reports a branch, the block may store the pair of addresses involved (where the jump came from and where it went) in a circular buffer. Whether a branch is stored depends on the control register, the hardware-loop flag and the current interrupt priority level. Debug software later reads the history back, newest entry first, through a small 32-bit register interface.

Two compression modes keep tight loops from flooding the buffer. When a new pair repeats the newest stored pair, or the one just before it, the block does not store it again. It sets bit 0 of an address in the matching entry instead. When the buffer is full, a control bit chooses what happens to a new branch. With the bit clear, the oldest entry is overwritten. With the bit set, the branch is refused and a one-cycle exception pulse is raised. The count that software reads saturates at a fixed limit, so older software that polls "until zero" still works with deeper buffers.

Control register bits: bit 0 power, bit 1 enable, bit 2 overflow-exception mode, bit 3 one-level compression, bit 4 two-level compression. Priority levels: 0 emulation, 1 reset, 2 non-maskable interrupt, 3 exception, larger values are lower priority. Register byte offsets: control 0x000, status 0x004, data 0x100.

Top module: `brtrace_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, a data read returns 0, and `ovf_exc_o` is low.
- R2: A branch is captured only while control bit 0 (power) and bit 1 (enable) are both set. With either bit clear the status count is unchanged.
- R3: A branch with `br_hwloop_i` high is never captured. A branch while `core_level_i` is 1 (reset level) is never captured.
- R4: At levels 0 to 3, a branch is dropped silently when control bit 2 is set. It is captured normally when bit 2 is clear.
- R5: When the buffer holds DEPTH entries and bit 2 is set, a qualifying branch is refused and no compression applies. The stored history stays the same, and `ovf_exc_o` is high for exactly the one cycle after the branch cycle.
- R6: When the buffer holds DEPTH entries and bit 2 is clear, a branch that is stored replaces the oldest entry.
- R7: With control bit 3 set and at least one entry present, a pair that equals the newest entry is not stored. The comparison ignores bit 0 of both addresses. Instead, bit 0 of the newest entry's destination is set.
- R8: With control bit 4 set and at least two entries present, a pair that equals the second-newest entry (bit 0 ignored) is not stored. Instead, bit 0 of that entry's source is set. The one-level check takes priority when both could match.
- R9: A read of offset 0x004 returns the number of valid entries, saturated at STAT_MAX (16).
- R10: Reads of offset 0x100 alternate between two words. The first returns the newest destination. The second returns the newest source and removes that entry. A read with the buffer empty returns 0 and changes nothing.
- R11: Only accesses with all four byte enables set take effect. Writes to 0x004 and 0x100 are ignored. A partial read returns 0 and removes nothing. Control reads back bits 4:0 with the upper bits zero.
- R12: When a branch and a data read fall in the same cycle, the capture is applied first, and the read sees the updated buffer.
- R13: Read data appears on `bus_rdata_o` in the cycle after the read access. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Taken-branch strobe, one cycle per branch |
| br_src_i | input | 32 | Branch source address |
| br_dst_i | input | 32 | Branch destination address |
| br_hwloop_i | input | 1 | Branch comes from a zero-overhead hardware loop |
| core_level_i | input | LVL_W | Current interrupt priority level of the core |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Register byte offset |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| ovf_exc_o | output | 1 | One-cycle overflow-exception pulse |

## Verification
The bench builds the block with DEPTH_LOG2 = 5, giving 32 entries, while STAT_MAX stays at 16. With these values the status count can exceed its saturation limit while the buffer still has room to fill. Both full-buffer policies and the wrap of the circular pointers are reached in a few dozen branches. The overwrite test stores 34 branches and drains the newest 32, which checks that the two oldest entries were evicted in order.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

  localparam int ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t src;
    addr_t dst;
  } pair_t;

  // control register bit positions
  localparam int CTRL_W    = 5;
  localparam int CTRL_PWR  = 0;
  localparam int CTRL_EN   = 1;
  localparam int CTRL_OVF  = 2;
  localparam int CTRL_CMP1 = 3;
  localparam int CTRL_CMP2 = 4;

  // register byte offsets
  localparam int OFF_W = 9;
  localparam logic [OFF_W-1:0] OFF_CTRL = 9'h000;
  localparam logic [OFF_W-1:0] OFF_STAT = 9'h004;
  localparam logic [OFF_W-1:0] OFF_DATA = 9'h100;

  // repeat detection ignores the marker bit 0
  function automatic logic same_pair(pair_t a, pair_t b);
    return (a.src[ADDR_W-1:1] == b.src[ADDR_W-1:1]) &&
           (a.dst[ADDR_W-1:1] == b.dst[ADDR_W-1:1]);
  endfunction

  function automatic pair_t mark_dst(pair_t p);
    pair_t r;
    r        = p;
    r.dst[0] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] sat_count(logic [31:0] n, logic [31:0] lim);
    return (n > lim) ? lim : n;
  endfunction

endpackage

// File: rtl/brtrace_gate.sv
module brtrace_gate
  import brtrace_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int RESET_LEVEL = 1,
  parameter int EXC_LEVEL   = 3
) (
  input  logic              br_valid,
  input  logic              br_hwloop,
  input  logic [LVL_W-1:0]  level,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              ev_ok,
  output logic              hi_drop
);

  logic powered;
  logic at_reset;
  logic hi_prio;

  always_comb begin
    powered  = ctrl[CTRL_PWR] & ctrl[CTRL_EN];
    at_reset = (level == LVL_W'(RESET_LEVEL));
    hi_prio  = (level <= LVL_W'(EXC_LEVEL));
    hi_drop  = hi_prio & ctrl[CTRL_OVF];
    ev_ok    = br_valid & powered & ~br_hwloop & ~at_reset & ~hi_drop;
  end

endmodule

// File: rtl/brtrace_store.sv
module brtrace_store
  import brtrace_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ev_ok,
  input  pair_t                 new_pair,
  input  logic [CTRL_W-1:0]     ctrl,
  input  logic                  pop,
  output pair_t                 newest,
  output logic [DEPTH_LOG2:0]   count_q,
  output logic [DEPTH_LOG2:0]   count_cap,
  output logic                  ev_reject,
  output logic                  ev_cmp1,
  output logic                  ev_cmp2,
  output logic                  ev_store,
  output logic                  ev_evict,
  output logic                  ovf_exc
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int AW    = DEPTH_LOG2;
  localparam int PW    = DEPTH_LOG2 + 1;

  pair_t          mem [DEPTH];
  logic [PW-1:0]  top_q, bot_q;
  logic [PW-1:0]  top_cap, bot_nx;
  logic [AW-1:0]  idx_top, idx_last, idx_ll;
  logic           full, has1, has2;
  logic           hit1, hit2;
  logic           ovf_q;

  always_comb begin
    count_q  = top_q - bot_q;
    full     = (count_q == PW'(DEPTH));
    has1     = (count_q != '0);
    has2     = (count_q > PW'(1));
    idx_top  = top_q[AW-1:0];
    idx_last = idx_top - AW'(1);
    idx_ll   = idx_top - AW'(2);
    hit1     = has1 & same_pair(new_pair, mem[idx_last]);
    hit2     = has2 & same_pair(new_pair, mem[idx_ll]);

    // outcome of one qualified branch, in priority order
    ev_reject = ev_ok & full & ctrl[CTRL_OVF];
    ev_cmp1   = ev_ok & ~ev_reject & ctrl[CTRL_CMP1] & hit1;
    ev_cmp2   = ev_ok & ~ev_reject & ~ev_cmp1 & ctrl[CTRL_CMP2] & hit2;
    ev_store  = ev_ok & ~ev_reject & ~ev_cmp1 & ~ev_cmp2;
    ev_evict  = ev_store & full;

    top_cap   = top_q + PW'(ev_store);
    bot_nx    = bot_q + PW'(ev_evict);
    count_cap = top_cap - bot_nx;

    // newest entry as it looks after this cycle's capture
    if (ev_store)      newest = new_pair;
    else if (ev_cmp1)  newest = mark_dst(mem[idx_last]);
    else               newest = mem[idx_last];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      bot_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      top_q <= top_cap - PW'(pop);
      bot_q <= bot_nx;
      ovf_q <= ev_reject;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ev_store) mem[idx_top] <= new_pair;
    if (ev_cmp1)  mem[idx_last].dst[0] <= 1'b1;
    if (ev_cmp2)  mem[idx_ll].src[0] <= 1'b1;
  end

  assign ovf_exc = ovf_q;

endmodule

// File: rtl/brtrace_regs.sv
module brtrace_regs
  import brtrace_pkg::*;
#(
  parameter int PW       = 5,
  parameter int STAT_MAX = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_wr_i,
  input  logic [OFF_W-1:0]  bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  input  pair_t             newest,
  input  logic [PW-1:0]     count_cap,
  output logic [CTRL_W-1:0] ctrl,
  output logic              pop,
  output logic [31:0]       rdata
);

  logic [CTRL_W-1:0] ctrl_q;
  logic              mid_q;
  logic [31:0]       rdata_q;
  logic              full_be, wr_ctrl, rd_any, rd_ok, data_rd, nonempty, step;
  logic [31:0]       rd_val;

  always_comb begin
    full_be  = (bus_be_i == 4'hF);
    wr_ctrl  = bus_en_i & bus_wr_i & full_be & (bus_addr_i == OFF_CTRL);
    rd_any   = bus_en_i & ~bus_wr_i;
    rd_ok    = rd_any & full_be;
    data_rd  = rd_ok & (bus_addr_i == OFF_DATA);
    nonempty = (count_cap != '0);
    step     = data_rd & nonempty;
    pop      = step & mid_q;

    rd_val = '0;
    if (rd_ok) begin
      case (bus_addr_i)
        OFF_CTRL: rd_val = 32'(ctrl_q);
        OFF_STAT: rd_val = sat_count(32'(count_cap), 32'(STAT_MAX));
        OFF_DATA: rd_val = nonempty ? (mid_q ? newest.src : newest.dst) : '0;
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mid_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q  <= bus_wdata_i[CTRL_W-1:0];
      if (step)    mid_q   <= ~mid_q;
      if (rd_any)  rdata_q <= rd_val;
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/brtrace_top.sv
module brtrace_top
  import brtrace_pkg::*;
#(
  parameter int DEPTH_LOG2  = 4,
  parameter int STAT_MAX    = 16,
  parameter int LVL_W       = 4,
  parameter int RESET_LEVEL = 1,
  parameter int EXC_LEVEL   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic [31:0]      br_src_i,
  input  logic [31:0]      br_dst_i,
  input  logic             br_hwloop_i,
  input  logic [LVL_W-1:0] core_level_i,
  input  logic             bus_en_i,
  input  logic             bus_wr_i,
  input  logic [8:0]       bus_addr_i,
  input  logic [3:0]       bus_be_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             ovf_exc_o
);

  localparam int PW = DEPTH_LOG2 + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ev_ok, hi_drop;
  logic              ev_reject, ev_cmp1, ev_cmp2, ev_store, ev_evict;
  logic              pop;
  logic [PW-1:0]     count_q, count_cap;
  pair_t             new_pair, newest;

  assign new_pair = '{src: br_src_i, dst: br_dst_i};

  brtrace_gate #(
    .LVL_W(LVL_W), .RESET_LEVEL(RESET_LEVEL), .EXC_LEVEL(EXC_LEVEL)
  ) u_gate (
    .br_valid (br_valid_i),
    .br_hwloop(br_hwloop_i),
    .level    (core_level_i),
    .ctrl     (ctrl_q),
    .ev_ok    (ev_ok),
    .hi_drop  (hi_drop)
  );

  brtrace_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_ok    (ev_ok),
    .new_pair (new_pair),
    .ctrl     (ctrl_q),
    .pop      (pop),
    .newest   (newest),
    .count_q  (count_q),
    .count_cap(count_cap),
    .ev_reject(ev_reject),
    .ev_cmp1  (ev_cmp1),
    .ev_cmp2  (ev_cmp2),
    .ev_store (ev_store),
    .ev_evict (ev_evict),
    .ovf_exc  (ovf_exc_o)
  );

  brtrace_regs #(.PW(PW), .STAT_MAX(STAT_MAX)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_en_i   (bus_en_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_be_i   (bus_be_i),
    .bus_wdata_i(bus_wdata_i),
    .newest     (newest),
    .count_cap  (count_cap),
    .ctrl       (ctrl_q),
    .pop        (pop),
    .rdata      (bus_rdata_o)
  );

endmodule

// File: rtl/brtrace_checker.sv
module brtrace_checker
  import brtrace_pkg::*;
#(
  parameter int DEPTH_LOG2  = 4,
  parameter int STAT_MAX    = 16,
  parameter int LVL_W       = 4,
  parameter int RESET_LEVEL = 1,
  parameter int EXC_LEVEL   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              br_hwloop_i,
  input logic [LVL_W-1:0]  core_level_i,
  input logic              bus_en_i,
  input logic              bus_wr_i,
  input logic [8:0]        bus_addr_i,
  input logic [3:0]        bus_be_i,
  input logic [31:0]       bus_rdata_o,
  input logic              ovf_exc_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              ev_ok,
  input logic              ev_store,
  input logic              ev_cmp1,
  input logic              ev_cmp2,
  input logic              ev_reject,
  input logic              ev_evict,
  input logic              pop,
  input logic [DEPTH_LOG2:0] count_q
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PW    = DEPTH_LOG2 + 1;

  a_r2_needs_power_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_store || ev_cmp1 || ev_cmp2 || ev_reject) |-> (ctrl_q[CTRL_PWR] && ctrl_q[CTRL_EN]));

  a_r3_loop_and_reset_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_hwloop_i || core_level_i == LVL_W'(RESET_LEVEL)) |-> !ev_ok);

  a_r4_high_level_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_level_i <= LVL_W'(EXC_LEVEL) && ctrl_q[CTRL_OVF]) |-> !ev_ok);

  a_r5_pulse_follows_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_reject |=> ovf_exc_o);

  a_r5_no_spurious_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_reject |=> !ovf_exc_o);

  a_r5_reject_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_reject && !pop) |=> (count_q == $past(count_q)));

  a_r6_evict_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_evict |-> (count_q == PW'(DEPTH)));

  a_r8_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_store, ev_cmp1, ev_cmp2, ev_reject}));

  a_r9_status_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_wr_i && bus_be_i == 4'hF && bus_addr_i == OFF_STAT)
      |=> (bus_rdata_o <= 32'(STAT_MAX)));

  a_r10_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= PW'(DEPTH));

  a_r11_partial_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_be_i != 4'hF) |-> !pop);

endmodule

bind brtrace_top brtrace_checker #(
  .DEPTH_LOG2(DEPTH_LOG2), .STAT_MAX(STAT_MAX), .LVL_W(LVL_W),
  .RESET_LEVEL(RESET_LEVEL), .EXC_LEVEL(EXC_LEVEL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_hwloop_i (br_hwloop_i),
  .core_level_i(core_level_i),
  .bus_en_i    (bus_en_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_rdata_o (bus_rdata_o),
  .ovf_exc_o   (ovf_exc_o),
  .ctrl_q      (ctrl_q),
  .ev_ok       (ev_ok),
  .ev_store    (ev_store),
  .ev_cmp1     (ev_cmp1),
  .ev_cmp2     (ev_cmp2),
  .ev_reject   (ev_reject),
  .ev_evict    (ev_evict),
  .pop         (pop),
  .count_q     (count_q)
);

// File: tb/brtrace_top_bench.sv
`timescale 1ns/1ps
module brtrace_top_bench;

  localparam int DLOG  = 5;
  localparam int DEPTH = 1 << DLOG;
  localparam int SMAX  = 16;
  localparam logic [8:0] A_CTRL = 9'h000;
  localparam logic [8:0] A_STAT = 9'h004;
  localparam logic [8:0] A_DATA = 9'h100;
  localparam logic [31:0] C_ON  = 32'h3;   // power + enable
  localparam logic [31:0] C_OVF = 32'h4;
  localparam logic [31:0] C_CP1 = 32'h8;
  localparam logic [31:0] C_CP2 = 32'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0, hw = 1'b0, ben = 1'b0, bwr = 1'b0;
  logic [31:0] bsrc = '0, bdst = '0, wdat = '0;
  logic [3:0]  lvl = 4'd8, bbe = 4'hF;
  logic [8:0]  badr = '0;
  logic [31:0] rdat;
  logic        ovf;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brtrace_top #(.DEPTH_LOG2(DLOG), .STAT_MAX(SMAX)) u_brtrace_top (
    .clk_i(clk), .rst_ni(rst_n),
    .br_valid_i(bv), .br_src_i(bsrc), .br_dst_i(bdst), .br_hwloop_i(hw),
    .core_level_i(lvl),
    .bus_en_i(ben), .bus_wr_i(bwr), .bus_addr_i(badr), .bus_be_i(bbe),
    .bus_wdata_i(wdat), .bus_rdata_o(rdat), .ovf_exc_o(ovf)
  );

  function automatic logic [31:0] src_of(int i); return 32'h1000 + 32'(i) * 16; endfunction
  function automatic logic [31:0] dst_of(int i); return 32'h8000 + 32'(i) * 16; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; results sampled 1 ns after the edge
  task automatic cyc(input logic v, input logic [31:0] s, input logic [31:0] d,
                     input logic h, input logic [3:0] l, input logic e,
                     input logic w, input logic [8:0] a, input logic [3:0] be,
                     input logic [31:0] wd);
    @(negedge clk);
    bv = v; bsrc = s; bdst = d; hw = h; lvl = l;
    ben = e; bwr = w; badr = a; bbe = be; wdat = wd;
    @(posedge clk);
    #1;
    bv = 1'b0; ben = 1'b0; hw = 1'b0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 4'd8, 0, 0, 0, 4'hF, 0);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    cyc(0, 0, 0, 0, 4'd8, 1, 1, a, be, d);
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v, input logic [3:0] be = 4'hF);
    cyc(0, 0, 0, 0, 4'd8, 1, 0, a, be, 0);
    v = rdat;
  endtask

  task automatic br(input logic [31:0] s, input logic [31:0] d,
                    input logic h = 1'b0, input logic [3:0] l = 4'd8);
    cyc(1, s, d, h, l, 0, 0, 0, 4'hF, 0);
  endtask

  task automatic br_i(input int i);
    br(src_of(i), dst_of(i));
  endtask

  // drain entries hi down to lo, then expect an empty read
  task automatic drain_range(input int hi, input int lo, input string req);
    logic [31:0] v;
    for (int i = hi; i >= lo; i--) begin
      rd(A_DATA, v); chk(req, v, dst_of(i));
      rd(A_DATA, v); chk(req, v, src_of(i));
    end
    rd(A_DATA, v); chk("R10 empty read", v, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 ovf low", 32'(ovf), 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_DATA, v); chk("R1 data", v, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    br_i(0);
    rd(A_STAT, v); chk("R2 all off", v, 0);
    wr(A_CTRL, 32'h1); br_i(0);
    rd(A_STAT, v); chk("R2 power only", v, 0);
    wr(A_CTRL, 32'h2); br_i(0);
    rd(A_STAT, v); chk("R2 enable only", v, 0);
    wr(A_CTRL, C_ON); br_i(0);
    rd(A_STAT, v); chk("R2 both on", v, 1);
    drain_range(0, 0, "R10 order");
  endtask

  task automatic t_filter();
    logic [31:0] v;
    wr(A_CTRL, C_ON);
    br(src_of(1), dst_of(1), 1'b1, 4'd8);
    rd(A_STAT, v); chk("R3 hwloop", v, 0);
    br(src_of(1), dst_of(1), 1'b0, 4'd1);
    rd(A_STAT, v); chk("R3 reset level", v, 0);
    br(src_of(1), dst_of(1), 1'b0, 4'd2);
    rd(A_STAT, v); chk("R4 high level, bit2 clear", v, 1);
    wr(A_CTRL, C_ON | C_OVF);
    br(src_of(2), dst_of(2), 1'b0, 4'd3);
    rd(A_STAT, v); chk("R4 high level, bit2 set", v, 1);
    chk("R4 silent drop", 32'(ovf), 0);
    br(src_of(2), dst_of(2), 1'b0, 4'd4);
    rd(A_STAT, v); chk("R4 low level", v, 2);
    drain_range(2, 1, "R4 contents");
  endtask

  task automatic t_compress();
    logic [31:0] v;
    wr(A_CTRL, C_ON | C_CP1 | C_CP2);
    br(32'h100, 32'h200);
    br(32'h101, 32'h201);
    rd(A_STAT, v); chk("R7 folded", v, 1);
    rd(A_DATA, v); chk("R7 dst marked", v, 32'h201);
    rd(A_DATA, v); chk("R7 src plain", v, 32'h100);
    br(32'h100, 32'h200); br(32'h300, 32'h400); br(32'h100, 32'h200);
    rd(A_STAT, v); chk("R8 folded", v, 2);
    rd(A_DATA, v); chk("R8 newest dst", v, 32'h400);
    rd(A_DATA, v); chk("R8 newest src", v, 32'h300);
    rd(A_DATA, v); chk("R8 older dst", v, 32'h200);
    rd(A_DATA, v); chk("R8 older src marked", v, 32'h101);
    // two equal entries stored uncompressed, then one-level wins
    wr(A_CTRL, C_ON);
    br(32'h100, 32'h200); br(32'h100, 32'h200);
    wr(A_CTRL, C_ON | C_CP1 | C_CP2);
    br(32'h100, 32'h200);
    rd(A_STAT, v); chk("R8 priority count", v, 2);
    rd(A_DATA, v); chk("R8 one-level first dst", v, 32'h201);
    rd(A_DATA, v); chk("R8 one-level first src", v, 32'h100);
    rd(A_DATA, v); chk("R8 second untouched dst", v, 32'h200);
    rd(A_DATA, v); chk("R8 second untouched src", v, 32'h100);
    rd(A_DATA, v); chk("R10 empty after", v, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(A_CTRL, C_ON);
    for (int i = 0; i < 10; i++) br_i(i);
    rd(A_STAT, v); chk("R9 below limit", v, 10);
    for (int i = 10; i < 20; i++) br_i(i);
    rd(A_STAT, v); chk("R9 saturated", v, SMAX);
    for (int i = 20; i < DEPTH + 2; i++) br_i(i);
    chk("R6 no pulse", 32'(ovf), 0);
    drain_range(DEPTH + 1, 2, "R6 oldest replaced");
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(A_CTRL, C_ON | C_OVF);
    for (int i = 0; i < DEPTH; i++) br_i(i);
    chk("R5 no pulse before full", 32'(ovf), 0);
    br_i(50);
    chk("R5 pulse", 32'(ovf), 1);
    idle();
    chk("R5 pulse one cycle", 32'(ovf), 0);
    br_i(DEPTH - 1);
    chk("R5 refused even if repeat", 32'(ovf), 1);
    idle();
    drain_range(DEPTH - 1, 0, "R5 history kept");
  endtask

  task automatic t_access();
    logic [31:0] v;
    wr(A_CTRL, C_ON);
    br_i(3);
    wr(A_CTRL, 32'h0, 4'h3);
    rd(A_CTRL, v); chk("R11 partial write", v, C_ON);
    wr(A_STAT, 32'h9); wr(A_DATA, 32'h9);
    rd(A_STAT, v); chk("R11 status write ignored", v, 1);
    rd(A_DATA, v, 4'h1); chk("R11 partial read", v, 0);
    rd(A_DATA, v); chk("R11 no pop on partial", v, dst_of(3));
    idle();
    chk("R13 read data held", rdat, dst_of(3));
    rd(A_DATA, v); chk("R10 src second", v, src_of(3));
    rd(A_DATA, v); chk("R10 empty", v, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R11 ctrl width", v, 32'h1F);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(A_CTRL, C_ON);
    br_i(5);
    cyc(1, src_of(6), dst_of(6), 0, 4'd8, 1, 0, A_DATA, 4'hF, 0);
    chk("R12 capture first", rdat, dst_of(6));
    rd(A_DATA, v); chk("R12 new src", v, src_of(6));
    rd(A_DATA, v); chk("R12 old dst", v, dst_of(5));
    rd(A_DATA, v); chk("R12 old src", v, src_of(5));
    cyc(1, src_of(7), dst_of(7), 0, 4'd8, 1, 0, A_DATA, 4'hF, 0);
    chk("R12 empty then capture", rdat, dst_of(7));
    rd(A_DATA, v); chk("R12 empty then capture src", v, src_of(7));
    rd(A_DATA, v); chk("R10 empty", v, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_filter();
    t_compress();
    t_wrap();
    t_overflow();
    t_access();
    t_same_cycle();
    finish_run();
  end

endmodule